// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss by walking a two-level page table held in memory. A requester hands it a virtual address together with the base address of the directory page. The walker reads one directory entry, checks it, uses the frame it names to locate and read one table entry, checks that, and then returns either the loaded table entry with the resulting physical address or a fault that says which level held an invalid entry.

The 32-bit virtual address carries a 10-bit directory index in bits 31:22, a 10-bit table index in bits 21:12 and a 12-bit offset in bits 11:0 (4 KB pages). Entries are 4 bytes wide. Bit 0 of an entry is its valid flag and bits 31:12 its frame number. Memory is reached through a plain read port: a one-cycle request with an address, and later a one-cycle response with data. The walker serves one miss at a time and holds `busy` high while it does. Fault handling, entry updates and the translation cache itself belong to other blocks.

Top module: `ptwalk_top`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises with no request, `busy`, `memRdValid`, `doneValid` and `faultValid` are all 0. A reset during a walk abandons it.
- R2: A `reqValid` seen while `busy` is 0 starts a walk. In the next cycle `busy` is 1 and `memRdValid` is 1 with `memRdAddr` = `dirBase` + 4 × `reqVaddr[31:22]`.
- R3: When the directory response is valid (bit 0 = 1), the cycle after it carries a second read with `memRdAddr` = {entry[31:12], 12'h000} + 4 × `reqVaddr[21:12]`.
- R4: A directory entry with bit 0 = 0 ends the walk in the cycle after the response with `faultValid` = 1 and `faultLevel` = 0, and no second read is issued.
- R5: A table entry with bit 0 = 0 ends the walk in the cycle after its response with `faultValid` = 1 and `faultLevel` = 1.
- R6: A table entry with bit 0 = 1 ends the walk in the cycle after its response with `doneValid` = 1, `donePte` equal to that entry, and `donePaddr` = {entry[31:12], `reqVaddr[11:0]`}.
- R7: `reqValid` while `busy` is 1 is ignored: the walk in progress keeps the address and base it was started with.
- R8: Each read request lasts one cycle; the walker waits any number of cycles (at least one) for its response, and `memRspValid` arriving while no read is outstanding is ignored.
- R9: `doneValid` and `faultValid` are never high together, each lasts one cycle with `busy` still 1, and `busy` is 0 in the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| reqValid | input | 1 | Start a walk for `reqVaddr` |
| reqVaddr | input | 32 | Virtual address that missed |
| dirBase | input | 32 | Byte address of the directory page |
| busy | output | 1 | A walk is in progress |
| memRdValid | output | 1 | One-cycle memory read request |
| memRdAddr | output | 32 | Byte address of the entry to read |
| memRspValid | input | 1 | Read data is present |
| memRspData | input | 32 | Entry returned by memory |
| doneValid | output | 1 | One-cycle pulse: translation ready |
| donePte | output | 32 | Loaded table entry |
| donePaddr | output | 32 | Translated physical address |
| faultValid | output | 1 | One-cycle pulse: walk found an invalid entry |
| faultLevel | output | 1 | 0 = directory entry invalid, 1 = table entry invalid |

## Verification
On every cycle the assertions check that a read request is a single-cycle pulse, that an accepted request raises `busy` and a read in the next cycle, that a result pulse appears only during a walk and is followed by an idle cycle, that a directory fault comes after exactly one read and a completion or table fault after exactly two, and that the offset of the completed address equals the offset of the accepted request. The addresses of both reads, the frame and entry contents returned, the level reported, and the immunity to a second request or a stray response during a walk depend on specific data and are shown only by the bench's scenarios, which vary index extremes, response latencies and entry validity.

// File: rtl/ptwalk_pkg.sv
package ptwalk_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_READ_DIR,
    S_WAIT_DIR,
    S_READ_PTE,
    S_WAIT_PTE,
    S_DONE,
    S_FAULT
  } walkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic captureReq;
    logic captureDir;
    logic capturePte;
    logic useTableAddr;
  } walkStrobe_t;

  localparam logic LEVEL_DIR = 1'b0;
  localparam logic LEVEL_PTE = 1'b1;

endpackage

// File: rtl/ptwalk_ctrl.sv
module ptwalk_ctrl
  import ptwalk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memRspValid,
  input  logic        rspValidBit,
  output walkStrobe_t strobe,
  output logic        busy,
  output logic        memRdValid,
  output logic        doneValid,
  output logic        faultValid,
  output logic        faultLevel
);

  walkState_t state, stateNext;
  logic       levelReg, levelNext;

  always_comb begin
    stateNext = state;
    levelNext = levelReg;
    unique case (state)
      S_IDLE:     if (reqValid) stateNext = S_READ_DIR;
      S_READ_DIR: stateNext = S_WAIT_DIR;
      S_WAIT_DIR: if (memRspValid) begin
                    if (rspValidBit) stateNext = S_READ_PTE;
                    else begin
                      stateNext = S_FAULT;
                      levelNext = LEVEL_DIR;
                    end
                  end
      S_READ_PTE: stateNext = S_WAIT_PTE;
      S_WAIT_PTE: if (memRspValid) begin
                    if (rspValidBit) stateNext = S_DONE;
                    else begin
                      stateNext = S_FAULT;
                      levelNext = LEVEL_PTE;
                    end
                  end
      S_DONE:     stateNext = S_IDLE;
      S_FAULT:    stateNext = S_IDLE;
      default:    stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      levelReg <= LEVEL_DIR;
    end else begin
      state    <= stateNext;
      levelReg <= levelNext;
    end
  end

  always_comb begin
    strobe.captureReq   = (state == S_IDLE) && reqValid;
    strobe.captureDir   = (state == S_WAIT_DIR) && memRspValid;
    strobe.capturePte   = (state == S_WAIT_PTE) && memRspValid;
    strobe.useTableAddr = (state == S_READ_PTE);
  end

  assign busy       = (state != S_IDLE);
  assign memRdValid = (state == S_READ_DIR) || (state == S_READ_PTE);
  assign doneValid  = (state == S_DONE);
  assign faultValid = (state == S_FAULT);
  assign faultLevel = levelReg;

endmodule

// File: rtl/ptwalk_dp.sv
module ptwalk_dp
  import ptwalk_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int PAGE_BITS   = 12,
  parameter int DIR_BITS    = 10,
  parameter int TBL_BITS    = 10,
  parameter int ENTRY_BYTES = 4,
  parameter int VALID_BIT   = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       strobe,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic [ADDR_W-1:0] dirBase,
  input  logic [ADDR_W-1:0] memRspData,
  output logic              rspValidBit,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic [ADDR_W-1:0] donePte,
  output logic [ADDR_W-1:0] donePaddr
);

  localparam int FRAME_W  = ADDR_W - PAGE_BITS;
  localparam int ENTRY_SH = $clog2(ENTRY_BYTES);

  logic [ADDR_W-1:0]  vaReg, baseReg, pteReg;
  logic [FRAME_W-1:0] dirFrame;
  logic [DIR_BITS-1:0] dirIdx;
  logic [TBL_BITS-1:0] tblIdx;
  logic [ADDR_W-1:0]  dirEntryAddr, tblEntryAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaReg    <= '0;
      baseReg  <= '0;
      pteReg   <= '0;
      dirFrame <= '0;
    end else begin
      if (strobe.captureReq) begin
        vaReg   <= reqVaddr;
        baseReg <= dirBase;
      end
      if (strobe.captureDir) dirFrame <= memRspData[ADDR_W-1:PAGE_BITS];
      if (strobe.capturePte) pteReg   <= memRspData;
    end
  end

  assign dirIdx = vaReg[ADDR_W-1 -: DIR_BITS];
  assign tblIdx = vaReg[PAGE_BITS +: TBL_BITS];

  assign dirEntryAddr = baseReg + (ADDR_W'(dirIdx) << ENTRY_SH);
  assign tblEntryAddr = {dirFrame, {PAGE_BITS{1'b0}}} + (ADDR_W'(tblIdx) << ENTRY_SH);

  assign memRdAddr   = strobe.useTableAddr ? tblEntryAddr : dirEntryAddr;
  assign rspValidBit = memRspData[VALID_BIT];
  assign donePte     = pteReg;
  assign donePaddr   = {pteReg[ADDR_W-1:PAGE_BITS], vaReg[PAGE_BITS-1:0]};

endmodule

// File: rtl/ptwalk_top.sv
module ptwalk_top
  import ptwalk_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int PAGE_BITS   = 12,
  parameter int DIR_BITS    = 10,
  parameter int TBL_BITS    = 10,
  parameter int ENTRY_BYTES = 4,
  parameter int VALID_BIT   = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic [ADDR_W-1:0] dirBase,
  output logic              busy,
  output logic              memRdValid,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic              memRspValid,
  input  logic [ADDR_W-1:0] memRspData,
  output logic              doneValid,
  output logic [ADDR_W-1:0] donePte,
  output logic [ADDR_W-1:0] donePaddr,
  output logic              faultValid,
  output logic              faultLevel
);

  walkStrobe_t strobe;
  logic        rspValidBit;

  ptwalk_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .memRspValid(memRspValid),
    .rspValidBit(rspValidBit),
    .strobe     (strobe),
    .busy       (busy),
    .memRdValid (memRdValid),
    .doneValid  (doneValid),
    .faultValid (faultValid),
    .faultLevel (faultLevel)
  );

  ptwalk_dp #(
    .ADDR_W     (ADDR_W),
    .PAGE_BITS  (PAGE_BITS),
    .DIR_BITS   (DIR_BITS),
    .TBL_BITS   (TBL_BITS),
    .ENTRY_BYTES(ENTRY_BYTES),
    .VALID_BIT  (VALID_BIT)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqVaddr   (reqVaddr),
    .dirBase    (dirBase),
    .memRspData (memRspData),
    .rspValidBit(rspValidBit),
    .memRdAddr  (memRdAddr),
    .donePte    (donePte),
    .donePaddr  (donePaddr)
  );

endmodule

// File: rtl/ptwalk_chk.sv
module ptwalk_chk #(
  parameter int PAGE_BITS = 12
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqValid,
  input logic [PAGE_BITS-1:0] vaOffIn,
  input logic                 busy,
  input logic                 memRdValid,
  input logic                 doneValid,
  input logic [PAGE_BITS-1:0] paOffOut,
  input logic                 faultValid,
  input logic                 faultLevel
);

  logic [1:0]           readCnt;
  logic [PAGE_BITS-1:0] offSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readCnt <= '0;
      offSeen <= '0;
    end else if (reqValid && !busy) begin
      readCnt <= '0;
      offSeen <= vaOffIn;
    end else if (memRdValid) begin
      readCnt <= readCnt + 2'd1;
    end
  end

  a_r2_accept_starts_read: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy) |=> (busy && memRdValid));

  a_r4_dir_fault_one_read: assert property (@(posedge clk) disable iff (!rstN)
    (faultValid && !faultLevel) |-> (readCnt == 2'd1));

  a_r5_pte_fault_two_reads: assert property (@(posedge clk) disable iff (!rstN)
    (faultValid && faultLevel) |-> (readCnt == 2'd2));

  a_r6_done_two_reads: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (readCnt == 2'd2));

  a_r6_offset_kept: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (paOffOut == offSeen));

  a_r8_read_pulse: assert property (@(posedge clk) disable iff (!rstN)
    memRdValid |=> !memRdValid);

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(doneValid && faultValid));

  a_r9_result_in_walk: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid || faultValid) |-> busy);

  a_r9_idle_after: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid || faultValid) |=> !busy);

endmodule

bind ptwalk_top ptwalk_chk #(.PAGE_BITS(PAGE_BITS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .vaOffIn   (reqVaddr[PAGE_BITS-1:0]),
  .busy      (busy),
  .memRdValid(memRdValid),
  .doneValid (doneValid),
  .paOffOut  (donePaddr[PAGE_BITS-1:0]),
  .faultValid(faultValid),
  .faultLevel(faultLevel)
);

// File: tb/sim_ptwalk_top.sv
module sim_ptwalk_top;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] va;
    logic [31:0] base;
    logic [31:0] dirE;
    logic [31:0] pteE;
    logic [3:0]  lat;
    logic        spur;
    logic        dup;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{32'h0040_1ABC, 32'h0010_0000, 32'h0020_3001, 32'h0055_5007, 4'd1, 1'b0, 1'b0},
    '{32'hFFFF_F123, 32'h0000_3000, 32'hABCD_E001, 32'h1234_5FFF, 4'd3, 1'b0, 1'b0},
    '{32'h0123_4567, 32'h0040_0000, 32'h0020_3000, 32'h0055_5007, 4'd2, 1'b0, 1'b0},
    '{32'h00C0_2FFF, 32'h0000_8000, 32'h0077_7003, 32'h0055_5FFE, 4'd1, 1'b0, 1'b0},
    '{32'h1234_5678, 32'h8000_0000, 32'h0000_1FFF, 32'hFFFF_F001, 4'd2, 1'b1, 1'b1},
    '{32'h0000_0000, 32'hFFFF_F000, 32'h0000_0001, 32'h0000_0001, 4'd5, 1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqVaddr = '0;
  logic [31:0] dirBase = '0;
  logic        busy, memRdValid, doneValid, faultValid, faultLevel;
  logic [31:0] memRdAddr, donePte, donePaddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptwalk_top u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVaddr(reqVaddr),
    .dirBase(dirBase), .busy(busy), .memRdValid(memRdValid),
    .memRdAddr(memRdAddr), .memRspValid(memRspValid), .memRspData(memRspData),
    .doneValid(doneValid), .donePte(donePte), .donePaddr(donePaddr),
    .faultValid(faultValid), .faultLevel(faultLevel)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %08h expected %08h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic runWalk(input vec_t v);
    logic [31:0] expDir, expTbl, expPa;
    expDir = v.base + ({22'd0, v.va[31:22]} << 2);
    expTbl = {v.dirE[31:12], 12'h000} + ({22'd0, v.va[21:12]} << 2);
    expPa  = {v.pteE[31:12], v.va[11:0]};
    reqVaddr = v.va;
    dirBase  = v.base;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    // R2: directory read the cycle after acceptance
    chk(busy && memRdValid, "R2 busy+read", {30'd0, busy, memRdValid}, 32'h3);
    chk(memRdAddr == expDir, "R2 dir address", memRdAddr, expDir);
    if (v.spur) begin
      memRspValid = 1'b1;
      memRspData  = 32'h0000_0000;
    end
    if (v.dup) begin
      reqValid = 1'b1;
      reqVaddr = v.va ^ 32'hFFFF_F000;
      dirBase  = ~v.base;
    end
    for (int i = 0; i < int'(v.lat); i++) begin
      @(negedge clk);
      memRspValid = 1'b0;
      reqValid    = 1'b0;
      chk(!memRdValid && busy, "R8 single-cycle read, waiting",
          {30'd0, busy, memRdValid}, 32'h2);
    end
    memRspValid = 1'b1;
    memRspData  = v.dirE;
    @(negedge clk);
    memRspValid = 1'b0;
    if (!v.dirE[0]) begin
      chk(faultValid && !faultLevel, "R4 directory fault level 0",
          {30'd0, faultValid, faultLevel}, 32'h2);
      chk(!memRdValid && !doneValid, "R4 no second read",
          {30'd0, memRdValid, doneValid}, 32'h0);
    end else begin
      chk(memRdValid, "R3 table read issued", {31'd0, memRdValid}, 32'h1);
      chk(memRdAddr == expTbl, v.dup ? "R7 table address after ignored request"
                                     : "R3 table address", memRdAddr, expTbl);
      for (int i = 0; i < int'(v.lat); i++) begin
        @(negedge clk);
        chk(!memRdValid && !doneValid && !faultValid, "R8 waiting for table",
            {29'd0, memRdValid, doneValid, faultValid}, 32'h0);
      end
      memRspValid = 1'b1;
      memRspData  = v.pteE;
      @(negedge clk);
      memRspValid = 1'b0;
      if (v.pteE[0]) begin
        chk(doneValid && !faultValid && busy, "R6/R9 done pulse",
            {29'd0, doneValid, faultValid, busy}, 32'h5);
        chk(donePte == v.pteE, "R6 loaded entry", donePte, v.pteE);
        chk(donePaddr == expPa, "R6 physical address", donePaddr, expPa);
      end else begin
        chk(faultValid && faultLevel && !doneValid, "R5 table fault level 1",
            {29'd0, faultValid, faultLevel, doneValid}, 32'h6);
      end
    end
    @(negedge clk);
    chk(!busy && !doneValid && !faultValid, "R9 idle after result",
        {29'd0, busy, doneValid, faultValid}, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    chk(!busy && !memRdValid && !doneValid && !faultValid, "R1 in reset",
        {28'd0, busy, memRdValid, doneValid, faultValid}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !memRdValid, "R1 after reset", {30'd0, busy, memRdValid}, 32'h0);

    foreach (VECS[k]) runWalk(VECS[k]);

    // R8: stray response while idle
    memRspValid = 1'b1;
    memRspData  = 32'hFFFF_FFFF;
    @(negedge clk);
    memRspValid = 1'b0;
    chk(!busy && !doneValid && !faultValid && !memRdValid, "R8 idle response ignored",
        {28'd0, busy, doneValid, faultValid, memRdValid}, 32'h0);
    @(negedge clk);
    chk(!doneValid && !faultValid, "R8 still no result",
        {30'd0, doneValid, faultValid}, 32'h0);

    // R1: reset during a walk
    reqVaddr = 32'h0040_0000;
    dirBase  = 32'h0000_1000;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk(!busy && !memRdValid, "R1 reset abandons walk", {30'd0, busy, memRdValid}, 32'h0);
    rstN = 1'b1;
    memRspValid = 1'b1;
    memRspData  = 32'h0000_3001;
    @(negedge clk);
    memRspValid = 1'b0;
    chk(!busy && !memRdValid && !doneValid, "R1 idle after mid-walk reset",
        {29'd0, busy, memRdValid, doneValid}, 32'h0);

    // R2 again after reset: fresh walk still works
    runWalk(VECS[0]);

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule